// File: doc/BRIEF.md
# NAND Factory Bad-Block Marker Checker

This block decides whether one NAND erase block carries a factory bad-block mark. A caller presents a block number and the bus width of the attached device. The checker then asks an external command sequencer to read the spare area of the first page of that block. The row address it supplies is the block number times the pages per block. The column it supplies lies past the end of the page data, at a configured marker offset.

When the sequencer reports that the data is ready, the checker drives one read strobe on the device's data bus. It captures the bus in the last clock of the low phase. On an 8-bit device it judges only the low byte. On a 16-bit device it judges both bytes of the word. Any judged byte other than 0xFF marks the block bad.

The verdict appears as a flag with a one-cycle valid pulse. If the sequencer gives up with a timeout, the block is reported bad and an error flag is raised. Scanning many blocks and keeping a table of the results are left to the caller.

Top module: `nand_bbm_check`

## Requirements
- R1: On an accepted request, `seq_row` becomes `chk_block * PAGES_PER_BLK`, which always points at page 0 of that block, and it is visible in the cycle after acceptance.
- R2: `seq_col` is `PAGE_BYTES + MARK_COL` when `chk_wide` is 0 (8-bit device). It is that value shifted right by one (a word address) when `chk_wide` is 1 (16-bit device).
- R3: `seq_req` rises in the cycle after a request is accepted. It stays high until the sequencer signals `seq_done` or `seq_timeout`, and it is low in the cycle after that signal is sampled.
- R4: After `seq_done` the checker pulls `nand_re_n` low for exactly `RE_CYC` clocks, once per check. It samples `nand_dq` on the clock edge that ends the low phase, so data present only in the last low cycle is the data judged.
- R5: With an 8-bit device the block is bad exactly when `nand_dq[7:0]` is not 0xFF. `nand_dq[15:8]` has no effect on the verdict.
- R6: With a 16-bit device the block is bad when either `nand_dq[7:0]` or `nand_dq[15:8]` is not 0xFF.
- R7: `res_valid` is a single-cycle pulse. It rises `RE_CYC + 1` clocks after the edge that samples `seq_done`, which is one clock after the bus sample.
- R8: `res_bad` and `res_err` hold their values until the next accepted request, which clears both.
- R9: A `seq_timeout` sampled while waiting sets `res_bad` and `res_err` and pulses `res_valid` one clock later, with no read strobe. A timeout takes priority over a simultaneous `seq_done`.
- R10: A request that arrives while a check is in progress is ignored. The address outputs do not change, and no further sequencer request follows the current check.
- R11: After reset, `seq_req`, `res_valid`, `res_bad` and `res_err` are 0 and `nand_re_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | Start a check (taken only when idle) |
| chk_block | input | BLK_W | Block number to check |
| chk_wide | input | 1 | 1 = 16-bit device bus, 0 = 8-bit |
| seq_req | output | 1 | Spare-area read request to the command sequencer |
| seq_row | output | BLK_W+log2(PAGES_PER_BLK) | Row (page) address for the sequencer |
| seq_col | output | log2(PAGE_BYTES)+1 | Column address for the sequencer |
| seq_done | input | 1 | Sequencer finished the command; data may be strobed |
| seq_timeout | input | 1 | Sequencer gave up waiting for the device |
| nand_dq | input | 16 | Device data bus |
| nand_re_n | output | 1 | Read strobe, active low |
| res_valid | output | 1 | One-cycle pulse: verdict updated |
| res_bad | output | 1 | Block is bad (or its check timed out) |
| res_err | output | 1 | Last check ended by a sequencer timeout |

## Verification
The assertions rely on the sequencer behaving in three ways. It raises `seq_done` or `seq_timeout` only while `seq_req` is high. It holds each of these signals for one clock. It does not start a command on its own while the read strobe is low.

The bench models the sequencer in a single thread that keeps to these rules. It waits a fixed number of clocks after seeing `seq_req`, then pulses exactly one completion signal (or both, for the priority case) for one clock. It drives the bus only while the strobe is low, and places the real marker only in the final low cycle. A sample taken at any other edge therefore reads zeros.

// File: rtl/nand_bbm_pkg.sv
package nand_bbm_pkg;

  // Check sequencing
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a request
    ST_WAIT = 2'd1,  // spare read requested, waiting for sequencer
    ST_READ = 2'd2   // strobing the marker from the bus
  } bbm_state_t;

endpackage

// File: rtl/nand_bbm_addr.sv
module nand_bbm_addr #(
  parameter int BLK_W         = 10,
  parameter int PAGES_PER_BLK = 64,
  parameter int PAGE_BYTES    = 2048,
  parameter int MARK_COL      = 0,
  localparam int PG_W  = $clog2(PAGES_PER_BLK),
  localparam int ROW_W = BLK_W + PG_W,
  localparam int COL_W = $clog2(PAGE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             wide_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             wide_o
);

  // Spare area begins right after the page data; the marker sits inside it.
  localparam logic [COL_W-1:0] COL_BYTE = COL_W'(PAGE_BYTES + MARK_COL);
  localparam logic [COL_W-1:0] COL_WORD = COL_BYTE >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_o  <= '0;
      col_o  <= '0;
      wide_o <= 1'b0;
    end else if (accept_i) begin
      row_o  <= {blk_i, {PG_W{1'b0}}};
      col_o  <= wide_i ? COL_WORD : COL_BYTE;
      wide_o <= wide_i;
    end
  end

endmodule

// File: rtl/nand_bbm_ctrl.sv
module nand_bbm_ctrl
  import nand_bbm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic seq_done_i,
  input  logic seq_to_i,
  input  logic samp_vld_i,
  output logic accept_o,
  output logic start_o,
  output logic to_evt_o,
  output logic seq_req_o
);

  bbm_state_t state;

  assign accept_o = (state == ST_IDLE) && req_i;
  assign to_evt_o = (state == ST_WAIT) && seq_to_i;
  assign start_o  = (state == ST_WAIT) && seq_done_i && !seq_to_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      seq_req_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept_o) begin
          state     <= ST_WAIT;
          seq_req_o <= 1'b1;
        end
        ST_WAIT: if (to_evt_o) begin
          state     <= ST_IDLE;
          seq_req_o <= 1'b0;
        end else if (start_o) begin
          state     <= ST_READ;
          seq_req_o <= 1'b0;
        end
        ST_READ: if (samp_vld_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the request drops once the sequencer has answered
  a_r3_req_drops: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && (seq_done_i || seq_to_i)) |=> !seq_req_o);

endmodule

// File: rtl/nand_bbm_strobe.sv
module nand_bbm_strobe #(
  parameter int RE_CYC = 3,
  localparam int CNT_W = (RE_CYC > 1) ? $clog2(RE_CYC) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [15:0] dq_i,
  output logic        re_n_o,
  output logic [15:0] word_o,
  output logic        samp_vld_o
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      re_n_o     <= 1'b1;
      cnt        <= '0;
      word_o     <= '0;
      samp_vld_o <= 1'b0;
    end else begin
      samp_vld_o <= 1'b0;
      if (start_i) begin
        re_n_o <= 1'b0;
        cnt    <= '0;
      end else if (!re_n_o) begin
        if (cnt == CNT_W'(RE_CYC - 1)) begin
          re_n_o     <= 1'b1;   // strobe rises on this edge
          word_o     <= dq_i;   // bus value from the last low cycle
          samp_vld_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a sample is always taken as the strobe leaves its low phase
  a_r4_sample_at_rise: assert property (@(posedge clk) disable iff (rst)
    samp_vld_o |-> (re_n_o && !$past(re_n_o)));

endmodule

// File: rtl/nand_bbm_judge.sv
module nand_bbm_judge (
  input  logic        clk,
  input  logic        rst,
  input  logic        accept_i,
  input  logic        wide_i,
  input  logic        samp_vld_i,
  input  logic [15:0] word_i,
  input  logic        to_evt_i,
  output logic        valid_o,
  output logic        bad_o,
  output logic        err_o
);

  logic [1:0] lane_erased;
  logic       mark_bad;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_erased[g] = (word_i[8*g +: 8] == 8'hFF);
  end

  assign mark_bad = wide_i ? !(&lane_erased) : !lane_erased[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      bad_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (accept_i) begin
        bad_o <= 1'b0;
        err_o <= 1'b0;
      end else if (to_evt_i) begin
        bad_o   <= 1'b1;
        err_o   <= 1'b1;
        valid_o <= 1'b1;
      end else if (samp_vld_i) begin
        bad_o   <= mark_bad;
        valid_o <= 1'b1;
      end
    end
  end

  // R7: the valid strobe lasts one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9: an error verdict is always a bad verdict
  a_r9_err_implies_bad: assert property (@(posedge clk) disable iff (rst)
    err_o |-> bad_o);

  // R8: the flag moves only with a verdict or a fresh request
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(bad_o) |-> (valid_o || $past(accept_i)));

endmodule

// File: rtl/nand_bbm_check.sv
module nand_bbm_check #(
  parameter int BLK_W         = 10,
  parameter int PAGES_PER_BLK = 64,
  parameter int PAGE_BYTES    = 2048,
  parameter int MARK_COL      = 0,
  parameter int RE_CYC        = 3
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    chk_req,
  input  logic [BLK_W-1:0]                        chk_block,
  input  logic                                    chk_wide,
  output logic                                    seq_req,
  output logic [BLK_W+$clog2(PAGES_PER_BLK)-1:0]  seq_row,
  output logic [$clog2(PAGE_BYTES):0]             seq_col,
  input  logic                                    seq_done,
  input  logic                                    seq_timeout,
  input  logic [15:0]                             nand_dq,
  output logic                                    nand_re_n,
  output logic                                    res_valid,
  output logic                                    res_bad,
  output logic                                    res_err
);

  logic        accept, start, to_evt, samp_vld, wide_q;
  logic [15:0] word;

  nand_bbm_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_i      (chk_req),
    .seq_done_i (seq_done),
    .seq_to_i   (seq_timeout),
    .samp_vld_i (samp_vld),
    .accept_o   (accept),
    .start_o    (start),
    .to_evt_o   (to_evt),
    .seq_req_o  (seq_req)
  );

  nand_bbm_addr #(
    .BLK_W         (BLK_W),
    .PAGES_PER_BLK (PAGES_PER_BLK),
    .PAGE_BYTES    (PAGE_BYTES),
    .MARK_COL      (MARK_COL)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .blk_i    (chk_block),
    .wide_i   (chk_wide),
    .row_o    (seq_row),
    .col_o    (seq_col),
    .wide_o   (wide_q)
  );

  nand_bbm_strobe #(.RE_CYC(RE_CYC)) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .dq_i       (nand_dq),
    .re_n_o     (nand_re_n),
    .word_o     (word),
    .samp_vld_o (samp_vld)
  );

  nand_bbm_judge u_judge (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .wide_i     (wide_q),
    .samp_vld_i (samp_vld),
    .word_i     (word),
    .to_evt_i   (to_evt),
    .valid_o    (res_valid),
    .bad_o      (res_bad),
    .err_o      (res_err)
  );

  // R10: addresses stay put while the sequencer is being asked
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (seq_req && $past(seq_req)) |-> ($stable(seq_row) && $stable(seq_col)));

  // R4: the strobe never overlaps an open sequencer request
  a_r4_no_strobe_in_cmd: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !seq_req);

endmodule

// File: tb/nand_bbm_check_test.sv
module nand_bbm_check_test;

  localparam int BLK_W  = 10;
  localparam int PAGES  = 64;
  localparam int PBYTES = 2048;
  localparam int MCOL   = 6;
  localparam int RE_CYC = 3;
  localparam int ROW_W  = BLK_W + $clog2(PAGES);
  localparam int COL_W  = $clog2(PBYTES) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk_req = 1'b0;
  logic [BLK_W-1:0] chk_block = '0;
  logic chk_wide = 1'b0;
  logic seq_req;
  logic [ROW_W-1:0] seq_row;
  logic [COL_W-1:0] seq_col;
  logic seq_done = 1'b0;
  logic seq_timeout = 1'b0;
  logic [15:0] nand_dq = 16'h0000;
  logic nand_re_n, res_valid, res_bad, res_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nand_bbm_check #(
    .BLK_W(BLK_W), .PAGES_PER_BLK(PAGES), .PAGE_BYTES(PBYTES),
    .MARK_COL(MCOL), .RE_CYC(RE_CYC)
  ) uut (
    .clk(clk), .rst(rst), .chk_req(chk_req), .chk_block(chk_block),
    .chk_wide(chk_wide), .seq_req(seq_req), .seq_row(seq_row),
    .seq_col(seq_col), .seq_done(seq_done), .seq_timeout(seq_timeout),
    .nand_dq(nand_dq), .nand_re_n(nand_re_n), .res_valid(res_valid),
    .res_bad(res_bad), .res_err(res_err)
  );

  typedef struct packed {
    logic             wide;
    logic [BLK_W-1:0] blk;
    logic [15:0]      dq;
    logic             to;
    logic             both;
    logic             bad;
    logic             err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd0,    16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 high byte ignored
    '{1'b0, 10'd3,    16'hFFFE, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 low byte marked
    '{1'b0, 10'd1023, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 top block
    '{1'b1, 10'd5,    16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 erased word
    '{1'b1, 10'd6,    16'h00FF, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 high byte marked
    '{1'b1, 10'd7,    16'hFF00, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 low byte marked
    '{1'b1, 10'd8,    16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1},  // R9 timeout
    '{1'b0, 10'd9,    16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1},  // R9 timeout beats done
    '{1'b0, 10'd2,    16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0}   // R8 error cleared
  };

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint exp_col(logic wide);
    longint c = PBYTES + MCOL;
    return wide ? (c >> 1) : c;
  endfunction

  task automatic run_vec(vec_t v);
    int lowcnt = 0;
    int vfirst = -1;
    int vcount = 0;
    logic vbad = 1'b0, verr = 1'b0;
    @(negedge clk);
    chk_req = 1'b1; chk_block = v.blk; chk_wide = v.wide;
    @(negedge clk);
    chk_req = 1'b0; chk_block = '0; chk_wide = ~v.wide;
    check_eq("R3", "seq_req after accept", seq_req, 1);
    check_eq("R1", "row", seq_row, longint'(v.blk) * PAGES);
    check_eq("R2", "col", seq_col, exp_col(v.wide));
    check_eq("R8", "flags cleared at accept", {res_bad, res_err}, 0);
    @(negedge clk); @(negedge clk);
    check_eq("R3", "seq_req held", seq_req, 1);
    seq_done = !v.to || v.both;
    seq_timeout = v.to;
    @(negedge clk);
    seq_done = 1'b0; seq_timeout = 1'b0;
    check_eq("R3", "seq_req dropped", seq_req, 0);
    for (int n = 1; n <= 30; n++) begin
      if (!nand_re_n) begin
        lowcnt++;
        nand_dq = (lowcnt == RE_CYC) ? v.dq : 16'h0000;
      end else begin
        nand_dq = 16'h0000;
      end
      if (res_valid) begin
        vcount++;
        if (vfirst < 0) begin vfirst = n; vbad = res_bad; verr = res_err; end
      end
      @(negedge clk);
    end
    check_eq(v.to ? "R9" : "R4", "strobe low cycles", lowcnt, v.to ? 0 : RE_CYC);
    check_eq(v.to ? "R9" : "R7", "valid latency", vfirst, v.to ? 1 : RE_CYC + 2);
    check_eq("R7", "valid pulse count", vcount, 1);
    check_eq(v.wide ? "R6" : "R5", "bad verdict", vbad, v.bad);
    check_eq("R9", "err verdict", verr, v.err);
    check_eq("R8", "bad held", res_bad, v.bad);
    check_eq("R8", "err held", res_err, v.err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check_eq("R11", "seq_req", seq_req, 0);
    check_eq("R11", "re_n", nand_re_n, 1);
    check_eq("R11", "valid/bad/err", {res_valid, res_bad, res_err}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: request during a check is ignored
    @(negedge clk);
    chk_req = 1'b1; chk_block = 10'd11; chk_wide = 1'b0;
    @(negedge clk);
    chk_req = 1'b1; chk_block = 10'd22; chk_wide = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
    check_eq("R10", "row unchanged", seq_row, 11 * PAGES);
    check_eq("R10", "col unchanged", seq_col, exp_col(1'b0));
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
    for (int n = 1; n <= 12; n++) begin
      nand_dq = !nand_re_n ? 16'h00FF : 16'h0000;
      if (n > 1) check_eq("R10", "no second request", seq_req, 0);
      @(negedge clk);
    end
    check_eq("R10", "original check verdict (8-bit)", res_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule